// File: doc/BRIEF.md
# Vector Byte Extract Unit

This block runs the vector byte extract operation of a SIMD pipeline. It decodes a 32-bit instruction word and treats the two source vectors as one double-width value, with the first operand in the low half and the second operand in the high half. It then shifts that value right by a whole number of bytes and returns the low bytes as the result. The byte shift comes from a 4-bit immediate in the instruction. A mode bit picks one of two widths:
- a 128-bit form that uses all 16 bytes of each operand;
- a 64-bit form that uses only the low 8 bytes of each operand and clears the upper half of the result.

The unit accepts an instruction word only when it is the extract operation. A sibling encoding in the same major opcode group performs an element move, and it differs in one bit. The unit refuses that encoding, every other unrelated word, and the reserved shift amounts of the 64-bit form. It refuses a word by raising a one-cycle undefined flag and producing no result.

The input and output are valid/ready streams with one register stage between them. The output register holds a result while the consumer applies back-pressure. The producer sees `in_ready` high only when that register is empty or is being drained in the same cycle.

Top module: `vext_unit`

## Requirements
- R1: A word is recognised only when all of these hold: bit 31 = 0, bits [29:21] = 9'b1_0111_0000, bit 15 = 0 and bit 10 = 0. An accepted word that fails any of these produces `out_undef` = 1 and `out_valid` = 0 in the next cycle.
- R2: A word that matches R1 except that bit 10 = 1 is the element-move sibling. It is refused with `out_undef`.
- R3: When bit 30 = 1 (16-byte mode), let s be bits [14:11]. Result byte j equals first-operand byte j+s when j+s < 16, and second-operand byte j+s-16 otherwise.
- R4: When bit 30 = 0 (8-byte mode), result byte j for j < 8 equals first-operand byte j+s when j+s < 8, and second-operand byte j+s-8 otherwise. Result bits [127:64] are zero. Operand bits [127:64] have no effect on the result.
- R5: In 8-byte mode, a shift amount with bit 3 set (s >= 8) is refused with `out_undef`.
- R6: A shift amount of 0 returns the first operand unchanged within the active width.
- R7: A word accepted in cycle t gives its result, or its undefined pulse, in cycle t+1. `out_undef` lasts one cycle and never coincides with `out_valid`.
- R8: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` holds steady.
- R9: After reset, `out_valid` and `out_undef` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| in_valid | input | 1 | An instruction and its operands are presented |
| in_ready | output | 1 | The unit can take a word in this cycle |
| in_insn | input | 32 | Instruction word |
| in_opa | input | 128 | First source vector (low half of the concatenation) |
| in_opb | input | 128 | Second source vector (high half of the concatenation) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Extracted vector |
| out_undef | output | 1 | One-cycle pulse for a refused word |

## Verification
A wrong byte-select term appears at once as a displaced or duplicated byte in `out_data`, one cycle after the word is accepted. The bench spreads distinct byte values across both operands, so each misplaced lane is visible on its own. A decode fault shows in the same cycle: a valid result where an undefined pulse is expected, or the reverse. A fault in the holding register shows only under back-pressure, as `out_data` changing or `in_ready` rising while a result is stalled, so the stall test checks both on every held cycle.

// File: rtl/vext_pkg.sv
package vext_pkg;
  localparam int unsigned VEC_BYTES = 16;
  localparam int unsigned IDX_W     = $clog2(VEC_BYTES);
  localparam int unsigned VEC_W     = VEC_BYTES * 8;
  localparam logic [8:0]  GRP_CODE  = 9'b1_0111_0000;

  typedef struct packed {
    logic             legal;
    logic             wide;
    logic [IDX_W-1:0] shift;
  } vext_dec_t;
endpackage

// File: rtl/vext_decode.sv
module vext_decode
  import vext_pkg::*;
(
  input  logic [31:0] insn,
  output vext_dec_t   dec
);
  logic group_hit;
  logic extract_hit;
  logic reserved_shift;
  logic unused_fields;

  assign group_hit      = (insn[31] == 1'b0) && (insn[29:21] == GRP_CODE);
  assign extract_hit    = group_hit && (insn[15] == 1'b0) && (insn[10] == 1'b0);
  assign reserved_shift = (insn[30] == 1'b0) && insn[11 + IDX_W - 1];
  assign unused_fields  = ^{insn[20:16], insn[9:0]};

  always_comb begin
    dec.legal = extract_hit && !reserved_shift;
    dec.wide  = insn[30];
    dec.shift = insn[11 +: IDX_W];
  end
endmodule

// File: rtl/vext_shift.sv
module vext_shift #(
  parameter int unsigned BYTES = 16,
  localparam int unsigned IW   = $clog2(BYTES),
  localparam int unsigned HALF = BYTES / 2,
  localparam int unsigned W    = BYTES * 8
) (
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic          wide,
  input  logic [IW-1:0] shift,
  output logic [W-1:0]  res
);
  logic [7:0] a_b [BYTES];
  logic [7:0] b_b [BYTES];

  for (genvar g = 0; g < BYTES; g++) begin : g_split
    assign a_b[g] = opa[g*8 +: 8];
    assign b_b[g] = opb[g*8 +: 8];
  end

  for (genvar j = 0; j < BYTES; j++) begin : g_lane
    logic [IW:0] pos;
    logic [7:0]  pick_wide;
    logic [7:0]  pick_half;

    assign pos = (IW+1)'(j) + {1'b0, shift};

    always_comb begin
      if (pos < (IW+1)'(BYTES)) pick_wide = a_b[pos[IW-1:0]];
      else                      pick_wide = b_b[pos[IW-1:0]];
    end

    if (j < HALF) begin : g_low
      always_comb begin
        if (pos < (IW+1)'(HALF))      pick_half = a_b[pos[IW-1:0]];
        else if (pos < (IW+1)'(BYTES)) pick_half = b_b[pos[IW-1:0] - IW'(HALF)];
        else                           pick_half = 8'h00;
      end
    end else begin : g_high
      assign pick_half = 8'h00;
    end

    assign res[j*8 +: 8] = wide ? pick_wide : pick_half;
  end
endmodule

// File: rtl/vext_unit.sv
module vext_unit
  import vext_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [31:0]  in_insn,
  input  logic [127:0] in_opa,
  input  logic [127:0] in_opb,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_data,
  output logic         out_undef
);
  vext_dec_t        dec;
  logic [VEC_W-1:0] shifted;
  logic             take;
  logic             wide_q;

  vext_decode u_dec (.insn(in_insn), .dec(dec));

  vext_shift #(.BYTES(VEC_BYTES)) u_shift (
    .opa(in_opa), .opb(in_opb), .wide(dec.wide), .shift(dec.shift), .res(shifted)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
      out_data  <= '0;
      wide_q    <= 1'b0;
    end else begin
      out_undef <= take && !dec.legal;
      if (take) begin
        out_valid <= dec.legal;
        if (dec.legal) begin
          out_data <= shifted;
          wide_q   <= dec.wide;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_UNDEF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_undef |-> !out_valid);  // R7
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R8
  AST_HALF_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide_q) |-> (out_data[127:64] == 64'h0));  // R4
  AST_RESERVED_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_insn[30] && in_insn[14]) |=> (out_undef && !out_valid));  // R5
  AST_SIBLING_REJ: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_insn[10]) |=> out_undef);  // R2
  AST_ONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dec.legal) |=> out_valid);  // R7
endmodule

// File: tb/test_vext_unit.sv
module test_vext_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_insn = '0;
  logic [127:0] in_opa = '0;
  logic [127:0] in_opb = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         out_undef;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vext_unit i_vext_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_opa(in_opa), .in_opb(in_opb),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_undef(out_undef)
  );

  function automatic logic [31:0] mk(input bit wide, input logic [3:0] s, input bit b10);
    return {1'b0, wide, 9'b1_0111_0000, 5'd3, 1'b0, s, b10, 5'd4, 5'd5};
  endfunction

  function automatic logic [127:0] model(input bit wide, input int s,
                                         input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = '0;
    int n = wide ? 16 : 8;
    for (int j = 0; j < n; j++) begin
      int k = j + s;
      r[j*8 +: 8] = (k < n) ? a[k*8 +: 8] : b[(k-n)*8 +: 8];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_opa = a; in_opb = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_ok(input string req, input bit wide, input int s,
                        input logic [127:0] a, input logic [127:0] b);
    send(mk(wide, 4'(s), 1'b0), a, b);
    check({req, " valid"}, {127'b0, out_valid}, 128'd1);
    check({req, " data"}, out_data, model(wide, s, a, b));
    check({req, " undef"}, {127'b0, out_undef}, 128'd0);
  endtask

  task automatic run_bad(input string req, input logic [31:0] w);
    send(w, {16{8'h5A}}, {16{8'hA5}});
    check({req, " undef"}, {127'b0, out_undef}, 128'd1);
    check({req, " no valid"}, {127'b0, out_valid}, 128'd0);
  endtask

  task automatic t_reset();
    check("R9 valid", {127'b0, out_valid}, 128'd0);
    check("R9 undef", {127'b0, out_undef}, 128'd0);
  endtask

  task automatic t_stall(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] first;
    out_ready = 1'b0;
    send(mk(1'b1, 4'd3, 1'b0), a, b);
    first = model(1'b1, 3, a, b);
    check("R8 stalled valid", {127'b0, out_valid}, 128'd1);
    check("R8 ready low", {127'b0, in_ready}, 128'd0);
    @(negedge clk);
    in_valid = 1'b1; in_insn = mk(1'b1, 4'd9, 1'b0); in_opa = b; in_opb = a;
    @(negedge clk);
    check("R8 data held", out_data, first);
    check("R8 still valid", {127'b0, out_valid}, 128'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next beat", out_data, model(1'b1, 9, b, a));
    @(negedge clk);
    check("R7 drained", {127'b0, out_valid}, 128'd0);
  endtask

  initial begin
    logic [127:0] a, b;
    for (int i = 0; i < 16; i++) begin
      a[i*8 +: 8] = 8'(8'h10 + i);
      b[i*8 +: 8] = 8'(8'hC0 + i);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_ok("R6 wide s0", 1'b1, 0, a, b);
    check("R6 wide equals a", out_data, a);
    run_ok("R3 wide s5", 1'b1, 5, a, b);
    run_ok("R3 wide s15", 1'b1, 15, a, b);
    run_ok("R4 half s3", 1'b0, 3, a, b);
    run_ok("R4 half s7", 1'b0, 7, a, b);
    run_ok("R6 half s0", 1'b0, 0, a, b);
    check("R6 half equals a low", out_data, {64'h0, a[63:0]});
    run_ok("R4 upper ignored", 1'b0, 5, {64'hFFFF_EEEE_DDDD_CCCC, a[63:0]},
           {64'h1234_5678_9ABC_DEF0, b[63:0]});
    check("R4 upper ignored ref", out_data, model(1'b0, 5, a, b));
    @(negedge clk);
    check("R7 one-cycle valid", {127'b0, out_valid}, 128'd0);
    run_bad("R5 half s8", mk(1'b0, 4'd8, 1'b0));
    @(negedge clk);
    check("R7 undef pulse ends", {127'b0, out_undef}, 128'd0);
    run_bad("R5 half s15", mk(1'b0, 4'd15, 1'b0));
    run_bad("R2 sibling", mk(1'b1, 4'd2, 1'b1));
    run_bad("R1 bit15", mk(1'b1, 4'd2, 1'b0) | 32'h0000_8000);
    run_bad("R1 bit31", mk(1'b1, 4'd2, 1'b0) | 32'h8000_0000);
    run_bad("R1 group", mk(1'b1, 4'd2, 1'b0) ^ 32'h0020_0000);
    t_stall(a, b);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule